// File: doc/BRIEF.md
# Oscillator Wake-Up Hold-Off and CPU Clock Divider

This block sits between a free-running oscillator clock and the processor core. After reset it waits for a start or wake request. It then keeps the CPU clock gated off while the oscillator settles. The length of that hold-off depends on the kind of clock source selected. Crystal sources get a long fixed count. On-chip oscillators and an externally driven clock get a short fixed count. Both counts are followed by a programmable settling count, which stands in for the analog settling time.

Once the hold-off ends, the block produces a one-cycle clock-enable pulse for every division period. The processor logic runs on the oscillator clock and qualifies its flops with this enable. Software sets the division through an 8-bit ratio register. The register can be rewritten at any time. A new value waits for the end of the period under way, so the enable stream never shows a short or a missing period. A separate low-power select bit is also held here and driven out to the memory interface logic.

Top module: `clk_wake_div`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `cpuClkEn`, `ready` and `lowPower` are 0. The ratio register also resets to 0, so the first run after reset delivers a pulse on every cycle.
- R2: For `srcSel` codes 0, 1 and 2 (the crystal sources), the first `cpuClkEn` pulse comes exactly `XTAL_HOLD + SETTLE_CYC` cycles after the clock edge that samples `startReq` high.
- R3: For `srcSel` codes 3 to 7 (on-chip oscillators and an external clock), the first pulse comes exactly `OTHER_HOLD + SETTLE_CYC` cycles after the edge that samples `startReq`.
- R4: Throughout the hold-off, `cpuClkEn` and `ready` stay 0.
- R5: A ratio register value of 0 selects bypass: `cpuClkEn` is high on every cycle.
- R6: A nonzero ratio value v gives one `cpuClkEn` pulse every 2·v cycles. The largest value, 255, gives a period of 510 cycles.
- R7: A ratio write changes the register at the sampling edge. The period already under way finishes with its old length. The new length applies from the first period that starts after the write edge, and no pulse is skipped or inserted in between.
- R8: `ready` rises in the same cycle as the first `cpuClkEn` pulse. It then stays high until the next reset.
- R9: A `startReq` that arrives during a hold-off or while running has no effect on the pulse stream or on `ready`.
- R10: Writing with `wrSel`=1 loads `wrData[0]` into the low-power bit, which is visible on `lowPower` from the next cycle. Writes with `wrSel`=0 leave the bit unchanged, and reset clears it.
- R11: A ratio write made before the hold-off ends sets the length of the very first period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Start or wake request, sampled on the rising edge |
| srcSel | input | 3 | Clock source kind: 0..2 crystal, 3..7 other |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 ratio register, 1 low-power bit |
| wrData | input | 8 | Write data (bit 0 only for the low-power bit) |
| cpuClkEn | output | 1 | One-cycle CPU clock enable pulse |
| ready | output | 1 | High from the first delivered pulse onward |
| lowPower | output | 1 | Low-power select bit |

## Verification
Outputs are decoded combinationally from registers, so each result belongs to the cycle after the edge that causes it. The first pulse and `ready` are due in the cycle numbered (start edge + hold total). A ratio write takes effect at the first pulse whose cycle number is greater than the write's cycle number. `lowPower` follows one cycle after its write edge. A reference model in the bench turns each stimulus into a per-cycle expectation keyed by cycle number. The monitor compares that expectation a fixed delay after the falling edge, so every comparison lands in the cycle where the result is due. Point checks at the cycle just before and the cycle of the first pulse confirm the hold-off boundary exactly.

// File: rtl/ckw_pkg.sv
package ckw_pkg;

  localparam int SRC_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_RUN  = 2'd2
  } wakeState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic running;      // enable stream may be produced
    logic reloadRatio;  // keep phase at zero and track the ratio register
  } ctlStrobe_t;

  // source codes 0..2 are crystal kinds, anything above is a fast-starting source
  function automatic logic isCrystalSrc(input logic [SRC_W-1:0] src);
    return (src <= SRC_W'(2));
  endfunction

endpackage

// File: rtl/ckw_ctrl.sv
module ckw_ctrl
  import ckw_pkg::*;
#(
  parameter int XTAL_HOLD  = 992,
  parameter int OTHER_HOLD = 224,
  parameter int SETTLE_CYC = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startReq,
  input  logic [SRC_W-1:0] srcSel,
  output ctlStrobe_t       strobe,
  output logic             ready
);

  localparam int XTAL_TOTAL  = XTAL_HOLD + SETTLE_CYC;
  localparam int OTHER_TOTAL = OTHER_HOLD + SETTLE_CYC;
  localparam int MAX_TOTAL   = (XTAL_TOTAL > OTHER_TOTAL) ? XTAL_TOTAL : OTHER_TOTAL;
  localparam int CNT_W       = $clog2(MAX_TOTAL + 1);
  localparam logic [CNT_W-1:0] XTAL_LOAD  = CNT_W'(XTAL_TOTAL - 1);
  localparam logic [CNT_W-1:0] OTHER_LOAD = CNT_W'(OTHER_TOTAL - 1);
  localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

  wakeState_t       stateQ;
  logic [CNT_W-1:0] holdCnt;
  logic             holdDone;

  assign holdDone = (holdCnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ  <= ST_IDLE;
      holdCnt <= '0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (startReq) begin
            holdCnt <= isCrystalSrc(srcSel) ? XTAL_LOAD : OTHER_LOAD;
            stateQ  <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (holdDone) stateQ <= ST_RUN;
          else          holdCnt <= holdCnt - CNT_ONE;
        end
        ST_RUN:  stateQ <= ST_RUN;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.running     = (stateQ == ST_RUN);
    strobe.reloadRatio = (stateQ != ST_RUN);
  end

  assign ready = (stateQ == ST_RUN);

endmodule

// File: rtl/ckw_datapath.sv
module ckw_datapath
  import ckw_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStrobe_t       strobe,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [DIV_W-1:0] wrData,
  output logic             cpuClkEn,
  output logic             lowPower
);

  localparam int PH_W = DIV_W + 1;
  localparam logic [PH_W-1:0] PH_ONE = PH_W'(1);

  logic [DIV_W-1:0] ratioReg;
  logic [DIV_W-1:0] ratioLive;
  logic [PH_W-1:0]  phaseCnt;
  logic [PH_W-1:0]  phaseLast;
  logic             phaseEnd;
  logic             lowPwrQ;

  // software-visible registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratioReg <= '0;
      lowPwrQ  <= 1'b0;
    end else if (wrEn) begin
      if (wrSel) lowPwrQ  <= wrData[0];
      else       ratioReg <= wrData;
    end
  end

  // period length is 2*ratio, or 1 when the ratio is zero
  always_comb begin
    if (ratioLive == '0) phaseLast = '0;
    else                 phaseLast = {ratioLive, 1'b0} - PH_ONE;
  end

  assign phaseEnd = (phaseCnt == phaseLast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratioLive <= '0;
      phaseCnt  <= '0;
    end else if (strobe.reloadRatio) begin
      ratioLive <= ratioReg;
      phaseCnt  <= '0;
    end else if (phaseEnd) begin
      ratioLive <= ratioReg;
      phaseCnt  <= '0;
    end else begin
      phaseCnt <= phaseCnt + PH_ONE;
    end
  end

  assign cpuClkEn = strobe.running && (phaseCnt == '0);
  assign lowPower = lowPwrQ;

endmodule

// File: rtl/clk_wake_div.sv
module clk_wake_div
  import ckw_pkg::*;
#(
  parameter int XTAL_HOLD  = 992,
  parameter int OTHER_HOLD = 224,
  parameter int SETTLE_CYC = 40,
  parameter int DIV_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startReq,
  input  logic [2:0]       srcSel,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [DIV_W-1:0] wrData,
  output logic             cpuClkEn,
  output logic             ready,
  output logic             lowPower
);

  ctlStrobe_t strobe;

  ckw_ctrl #(
    .XTAL_HOLD (XTAL_HOLD),
    .OTHER_HOLD(OTHER_HOLD),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .startReq(startReq),
    .srcSel  (srcSel),
    .strobe  (strobe),
    .ready   (ready)
  );

  ckw_datapath #(
    .DIV_W(DIV_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .wrData  (wrData),
    .cpuClkEn(cpuClkEn),
    .lowPower(lowPower)
  );

endmodule

// File: rtl/ckw_checker.sv
module ckw_checker
  import ckw_pkg::*;
#(
  parameter int XTAL_HOLD  = 992,
  parameter int OTHER_HOLD = 224,
  parameter int SETTLE_CYC = 40,
  parameter int DIV_W      = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             startReq,
  input logic [2:0]       srcSel,
  input logic             wrEn,
  input logic             wrSel,
  input logic [DIV_W-1:0] wrData,
  input logic             cpuClkEn,
  input logic             ready,
  input logic             lowPower
);

  localparam int MAX_GAP = 2 * ((1 << DIV_W) - 1);

  logic waiting;
  int   waitCnt;
  int   waitExp;
  int   gap;
  logic seenPulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting   <= 1'b0;
      waitCnt   <= 0;
      waitExp   <= 0;
      gap       <= 0;
      seenPulse <= 1'b0;
    end else begin
      if (!waiting && !ready && startReq) begin
        waiting <= 1'b1;
        waitCnt <= 0;
        waitExp <= isCrystalSrc(srcSel) ? (XTAL_HOLD + SETTLE_CYC)
                                        : (OTHER_HOLD + SETTLE_CYC);
      end else if (waiting) begin
        waitCnt <= waitCnt + 1;
        if (ready) waiting <= 1'b0;
      end
      if (cpuClkEn) begin
        gap       <= 1;
        seenPulse <= 1'b1;
      end else if (gap < 4096) begin
        gap <= gap + 1;
      end
    end
  end

  // R2 and R3: hold-off length follows the source kind
  assert_hold_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (waitCnt == waitExp));

  // R4: nothing leaves the block before ready
  assert_no_early_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpuClkEn |-> ready);

  assert_first_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> cpuClkEn);

  assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R6: periods are one cycle or an even count no longer than the maximum
  assert_even_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuClkEn && seenPulse) |-> ((gap == 1) || ((gap % 2 == 0) && (gap <= MAX_GAP))));

  assert_lp_write_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wrEn && wrSel) |-> $stable(lowPower));

endmodule

bind clk_wake_div ckw_checker #(
  .XTAL_HOLD (XTAL_HOLD),
  .OTHER_HOLD(OTHER_HOLD),
  .SETTLE_CYC(SETTLE_CYC),
  .DIV_W     (DIV_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .startReq(startReq),
  .srcSel  (srcSel),
  .wrEn    (wrEn),
  .wrSel   (wrSel),
  .wrData  (wrData),
  .cpuClkEn(cpuClkEn),
  .ready   (ready),
  .lowPower(lowPower)
);

// File: tb/clk_wake_div_bench.sv
module clk_wake_div_bench;

  localparam int XTAL_HOLD  = 992;
  localparam int OTHER_HOLD = 224;
  localparam int SETTLE_CYC = 40;
  localparam int DIV_W      = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             startReq = 1'b0;
  logic [2:0]       srcSel = 3'd0;
  logic             wrEn = 1'b0;
  logic             wrSel = 1'b0;
  logic [DIV_W-1:0] wrData = '0;
  logic             cpuClkEn;
  logic             ready;
  logic             lowPower;

  clk_wake_div #(
    .XTAL_HOLD (XTAL_HOLD),
    .OTHER_HOLD(OTHER_HOLD),
    .SETTLE_CYC(SETTLE_CYC),
    .DIV_W     (DIV_W)
  ) u_clk_wake_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .startReq(startReq),
    .srcSel  (srcSel),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .wrData  (wrData),
    .cpuClkEn(cpuClkEn),
    .ready   (ready),
    .lowPower(lowPower)
  );

  always #5 clk = ~clk;

  int    cyc = 0;
  int    nRun = 0;
  int    nFail = 0;
  bit    finished = 1'b0;
  string curTag = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  // reference state, derived from the requirements
  bit started;
  int firstPulse, nextPulse, curR;
  bit pendValid;
  int pendR, pendW;
  bit lpExp, lpNext;
  int lpFrom;

  typedef struct {
    int    cycNo;
    bit    en;
    bit    rdy;
    bit    lp;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  function automatic int ratioOf(input int v);
    return (v == 0) ? 1 : 2 * v;
  endfunction

  task automatic modelReset();
    started   = 1'b0;
    firstPulse = 0;
    nextPulse = -1;
    curR      = 1;
    pendValid = 1'b0;
    pendR     = 1;
    pendW     = 0;
    lpExp     = 1'b0;
    lpNext    = 1'b0;
    lpFrom    = 0;
  endtask

  // driver side: one expected item per cycle
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      expItem_t it;
      it.cycNo = cyc;
      it.tag   = curTag;
      if (cyc >= lpFrom) lpExp = lpNext;
      it.lp  = lpExp;
      it.rdy = started && (cyc >= firstPulse);
      it.en  = started && (cyc == nextPulse);
      if (it.en) begin
        if (pendValid && (cyc > pendW)) begin
          curR      = pendR;
          pendValid = 1'b0;
        end
        nextPulse = cyc + curR;
      end
      expQ.push_back(it);
    end
  end

  // monitor side
  always @(negedge clk) begin
    #2;
    while (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      nRun++;
      if (cpuClkEn !== it.en || ready !== it.rdy || lowPower !== it.lp) begin
        nFail++;
        $display("FAIL %s cycle %0d: en/ready/lowPower = %b%b%b expected %b%b%b",
                 it.tag, it.cycNo, cpuClkEn, ready, lowPower, it.en, it.rdy, it.lp);
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic expv, input string what);
    nRun++;
    if (act !== expv) begin
      nFail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, expv);
    end
  endtask

  task automatic waitCyc(input int n);
    while (cyc < n) @(negedge clk);
    #3;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    modelReset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wake(input logic [2:0] src);
    int holdTotal;
    @(negedge clk);
    startReq = 1'b1;
    srcSel   = src;
    holdTotal = (src <= 3'd2) ? (XTAL_HOLD + SETTLE_CYC) : (OTHER_HOLD + SETTLE_CYC);
    if (!started) begin
      started    = 1'b1;
      firstPulse = cyc + 1 + holdTotal;
      nextPulse  = firstPulse;
    end
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic writeRatio(input int v);
    @(negedge clk);
    wrEn   = 1'b1;
    wrSel  = 1'b0;
    wrData = DIV_W'(v);
    pendValid = 1'b1;
    pendR     = ratioOf(v);
    pendW     = cyc + 1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic writeLp(input bit b);
    @(negedge clk);
    wrEn   = 1'b1;
    wrSel  = 1'b1;
    wrData = {{(DIV_W-1){1'b1}}, b};
    lpNext = b;
    lpFrom = cyc + 1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runFor(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    #3;
    curTag = "R1";
    check("R1", cpuClkEn, 1'b0, "enable in reset");
    check("R1", ready,    1'b0, "ready in reset");
    check("R1", lowPower, 1'b0, "lowPower in reset");
    @(negedge clk);
    rst_n = 1'b1;
    #3;
    check("R1", cpuClkEn, 1'b0, "enable after release");
    check("R1", ready,    1'b0, "ready after release");

    // crystal wake, with a second request during the hold-off
    curTag = "R2";
    wake(3'd1);
    runFor(100);
    curTag = "R9";
    wake(3'd3);
    curTag = "R4";
    waitCyc(firstPulse - 1);
    check("R4", ready,    1'b0, "ready one cycle before hold end");
    check("R4", cpuClkEn, 1'b0, "enable one cycle before hold end");
    waitCyc(firstPulse);
    check("R2", cpuClkEn, 1'b1, "first pulse at crystal hold end");
    check("R8", ready,    1'b1, "ready with first pulse");
    curTag = "R5";
    runFor(20);

    curTag = "R7";
    writeRatio(3);
    runFor(40);
    writeLp(1'b1);
    runFor(4);
    check("R10", lowPower, 1'b1, "lowPower after write");
    curTag = "R6";
    writeRatio(255);
    runFor(1100);
    curTag = "R9";
    wake(3'd0);
    curTag = "R7";
    writeRatio(1);
    runFor(560);
    check("R10", lowPower, 1'b1, "lowPower kept over ratio writes");
    curTag = "R5";
    writeRatio(0);
    runFor(20);
    curTag = "R10";
    writeLp(1'b0);
    runFor(3);

    // reset, early ratio write, fast source
    writeLp(1'b1);
    runFor(2);
    curTag = "R1";
    doReset();
    #3;
    check("R1", lowPower, 1'b0, "lowPower cleared by reset");
    check("R1", ready,    1'b0, "ready cleared by reset");
    curTag = "R11";
    writeRatio(2);
    curTag = "R3";
    wake(3'd4);
    waitCyc(firstPulse - 1);
    check("R3", ready, 1'b0, "ready before short hold end");
    waitCyc(firstPulse);
    check("R3", cpuClkEn, 1'b1, "first pulse at short hold end");
    curTag = "R11";
    waitCyc(firstPulse + 1);
    check("R11", cpuClkEn, 1'b0, "no pulse inside first period");
    waitCyc(firstPulse + 4);
    check("R11", cpuClkEn, 1'b1, "second pulse after 4 cycles");
    runFor(30);

    // high-frequency crystal code after a reset with bypass
    curTag = "R1";
    doReset();
    curTag = "R2";
    wake(3'd2);
    waitCyc(firstPulse);
    check("R2", cpuClkEn, 1'b1, "first pulse for crystal code 2");
    runFor(10);

    @(negedge clk);
    #4;
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule